// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

A four-bit presettable counter whose state bits all change together on the rising clock edge. A build-time parameter chooses between decade counting (0 to 9) and full binary counting (0 to 15). On any edge the counter does one of four things: it takes a parallel value, it steps up, it steps down, or it keeps its value. Which one is set by an active-low synchronous load, two active-low count enables and a direction input.

An active-low look-ahead carry is formed combinationally from the present count, the direction and the second enable. It can drive the second enable of the next stage directly, and the first enable of every stage is tied to a common enable. Several stages then form a wider synchronous counter with no extra gating, and every stage updates on the same edge.

Top module: `updn_counter`

## Requirements
- R1: The count changes only at a rising clock edge. A change of load, data, enables or direction between edges leaves the output unchanged until the next rising edge.
- R2: When load_n is low at a rising edge, the count takes the value of din.
- R3: When load_n is high and either en_p_n or en_t_n is high at a rising edge, the count keeps its value.
- R4: When load_n is high and both enables are low at a rising edge, the count steps by one. It increments when up is 1 and decrements when up is 0.
- R5: Wrap points. In decade mode an up-step from 9 gives 0 and a down-step from 0 gives 9. In binary mode an up-step from 15 gives 0 and a down-step from 0 gives 15.
- R6: carry_n is 0 exactly when en_t_n is 0 and the count is terminal. The terminal count is 9 (decade) or 15 (binary) when up is 1, and 0 when up is 0.
- R7: en_p_n has no effect on carry_n.
- R8: In decade mode, a loaded value from 10 to 15 steps up to value+1 modulo 16 (15 gives 0) and steps down to value-1. carry_n stays 1 for these values.
- R9: carry_n follows the inputs in the same cycle. With each stage's carry_n driving the next stage's en_t_n and a shared en_p_n, two stages count as one 8-bit counter, either binary or two BCD digits, in both directions.
- R10: Load takes priority over the enables. A low load_n loads din even when both enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| load_n | input | 1 | Synchronous parallel load, active low |
| din | input | DW | Parallel data taken on load |
| en_p_n | input | 1 | Count enable, active low; does not reach the carry |
| en_t_n | input | 1 | Count enable, active low; also gates the carry |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| q | output | DW | Present count |
| carry_n | output | 1 | Look-ahead carry, active low, at the terminal count |

## Verification
The assertions check on every cycle that a load takes the data, that a disabled counter holds, that single steps and wraps are correct for each direction, and that the carry is never low while en_t_n is high or while the count is outside the decade range. The bench scenarios show the behaviours that need more than one cycle or more than one stage: 8-bit sequences through two cascaded stages, compared with an independent model across the 255/0 and 99/0 boundaries in both directions. They also cover carry values for chosen counts, the walk of out-of-range decade values, and the fact that control changes between edges leave the count untouched.

// File: rtl/updn_pkg.sv
package updn_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } op_e;
endpackage

// File: rtl/updn_decode.sv
module updn_decode
    import updn_pkg::*;
(
    input  logic load_n,
    input  logic en_p_n,
    input  logic en_t_n,
    input  logic up,
    output op_e  op
);
    always_comb begin
        if (!load_n)                 op = OP_LOAD;
        else if (en_p_n || en_t_n)   op = OP_HOLD;
        else if (up)                 op = OP_INC;
        else                         op = OP_DEC;
    end
endmodule

// File: rtl/updn_next.sv
module updn_next #(
    parameter int              DW   = 4,
    parameter logic [DW-1:0]   LAST = 4'd9
) (
    input  logic [DW-1:0] cur,
    output logic [DW-1:0] inc,
    output logic [DW-1:0] dec
);
    // up: only the terminal value wraps; others (incl. out of range) add one modulo 2^DW
    always_comb begin
        if (cur == LAST) inc = '0;
        else             inc = cur + 1'b1;
        if (cur == '0)   dec = LAST;
        else             dec = cur - 1'b1;
    end
endmodule

// File: rtl/updn_term.sv
module updn_term #(
    parameter int              DW   = 4,
    parameter logic [DW-1:0]   LAST = 4'd9
) (
    input  logic [DW-1:0] cur,
    input  logic          up,
    input  logic          en_t_n,
    output logic          carry_n
);
    logic at_top, at_bottom;
    always_comb begin
        at_top    = (cur == LAST);
        at_bottom = (cur == '0);
        carry_n   = !(!en_t_n && (up ? at_top : at_bottom));
    end
endmodule

// File: rtl/updn_counter.sv
module updn_counter
    import updn_pkg::*;
#(
    parameter int DW     = 4,
    parameter bit DECADE = 1'b1
) (
    input  logic          clk,
    input  logic          load_n,
    input  logic [DW-1:0] din,
    input  logic          en_p_n,
    input  logic          en_t_n,
    input  logic          up,
    output logic [DW-1:0] q,
    output logic          carry_n
);
    localparam logic [DW-1:0] LAST = DECADE ? DW'(9) : {DW{1'b1}};

    typedef struct packed {
        logic [DW-1:0] cnt;
    } state_t;

    state_t        st_d, st_q;
    op_e           op_d;
    logic [DW-1:0] inc_d, dec_d;

    updn_decode u_dec (
        .load_n (load_n),
        .en_p_n (en_p_n),
        .en_t_n (en_t_n),
        .up     (up),
        .op     (op_d)
    );

    updn_next #(.DW(DW), .LAST(LAST)) u_next (
        .cur (st_q.cnt),
        .inc (inc_d),
        .dec (dec_d)
    );

    updn_term #(.DW(DW), .LAST(LAST)) u_term (
        .cur     (st_q.cnt),
        .up      (up),
        .en_t_n  (en_t_n),
        .carry_n (carry_n)
    );

    always_comb begin
        st_d = st_q;
        unique case (op_d)
            OP_LOAD: st_d.cnt = din;
            OP_INC:  st_d.cnt = inc_d;
            OP_DEC:  st_d.cnt = dec_d;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.cnt;

    // Assertion window opens after the first edge so $past has a sampled history
    logic armed_q = 1'b0;
    always_ff @(posedge clk) armed_q <= 1'b1;

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!armed_q)
        !$past(load_n) |-> q == $past(din));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!armed_q)
        ($past(load_n) && ($past(en_p_n) || $past(en_t_n))) |-> $stable(q));

    // R4
    up_step_chk: assert property (@(posedge clk) disable iff (!armed_q)
        ($past(load_n) && !$past(en_p_n) && !$past(en_t_n) && $past(up) && $past(q) != LAST)
        |-> q == DW'($past(q) + 1'b1));

    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (!armed_q)
        ($past(load_n) && !$past(en_p_n) && !$past(en_t_n) && !$past(up) && $past(q) != '0)
        |-> q == DW'($past(q) - 1'b1));

    // R5
    up_wrap_chk: assert property (@(posedge clk) disable iff (!armed_q)
        ($past(load_n) && !$past(en_p_n) && !$past(en_t_n) && $past(up) && $past(q) == LAST)
        |-> q == '0);

    // R5
    down_wrap_chk: assert property (@(posedge clk) disable iff (!armed_q)
        ($past(load_n) && !$past(en_p_n) && !$past(en_t_n) && !$past(up) && $past(q) == '0)
        |-> q == LAST);

    // R6
    carry_gate_chk: assert property (@(posedge clk) disable iff (!armed_q)
        en_t_n |-> carry_n);

    generate
        if (DECADE) begin : g_dec_chk
            // R8
            oor_carry_chk: assert property (@(posedge clk) disable iff (!armed_q)
                (q > LAST) |-> carry_n);
        end
    endgenerate
endmodule

// File: tb/updn_counter_test.sv
module updn_counter_test;
    logic       clk = 1'b0;
    logic       ld_n = 1'b1, ep_n = 1'b1, et_n = 1'b1, up = 1'b1;
    logic [7:0] dat_b = '0, dat_d = '0;
    logic [3:0] b_lo, b_hi, d_lo, d_hi;
    logic       bc_lo, bc_hi, dc_lo, dc_hi;
    int         checks = 0, fails = 0;
    logic [7:0] bref = '0;
    int         dref = 0;

    always #10 clk = ~clk;

    // binary cascade: uut is the low stage
    updn_counter #(.DW(4), .DECADE(1'b0)) uut (
        .clk(clk), .load_n(ld_n), .din(dat_b[3:0]), .en_p_n(ep_n), .en_t_n(et_n),
        .up(up), .q(b_lo), .carry_n(bc_lo));
    updn_counter #(.DW(4), .DECADE(1'b0)) uut_hi (
        .clk(clk), .load_n(ld_n), .din(dat_b[7:4]), .en_p_n(ep_n), .en_t_n(bc_lo),
        .up(up), .q(b_hi), .carry_n(bc_hi));
    // decade cascade
    updn_counter #(.DW(4), .DECADE(1'b1)) dec_lo (
        .clk(clk), .load_n(ld_n), .din(dat_d[3:0]), .en_p_n(ep_n), .en_t_n(et_n),
        .up(up), .q(d_lo), .carry_n(dc_lo));
    updn_counter #(.DW(4), .DECADE(1'b1)) dec_hi (
        .clk(clk), .load_n(ld_n), .din(dat_d[7:4]), .en_p_n(ep_n), .en_t_n(dc_lo),
        .up(up), .q(d_hi), .carry_n(dc_hi));

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one edge with a model update, then compare both cascades
    task automatic tick(input string req);
        if (!ld_n) begin
            bref = dat_b;
            dref = int'(dat_d[7:4]) * 10 + int'(dat_d[3:0]);
        end else if (!ep_n && !et_n) begin
            if (up) begin bref = bref + 8'd1; dref = (dref + 1) % 100; end
            else    begin bref = bref - 8'd1; dref = (dref + 99) % 100; end
        end
        @(posedge clk); #1;
        chk({b_hi, b_lo} == bref, req, int'({b_hi, b_lo}), int'(bref));
        chk(int'(d_hi) * 10 + int'(d_lo) == dref && d_lo <= 4'd9 && d_hi <= 4'd9,
            req, int'(d_hi) * 10 + int'(d_lo), dref);
    endtask

    task automatic load_both(input logic [7:0] vb, input logic [7:0] vd, input string req);
        ld_n = 1'b0; dat_b = vb; dat_d = vd;
        tick(req);
        ld_n = 1'b1;
    endtask

    task automatic t_load;
        load_both(8'h00, 8'h00, "R2 reset state via load");
        load_both(8'hA5, 8'h37, "R2 load");
        ep_n = 1'b1; et_n = 1'b1;
        load_both(8'h3C, 8'h82, "R10 load with enables high");
    endtask

    task automatic t_hold;
        load_both(8'h47, 8'h46, "R3 preset");
        ep_n = 1'b1; et_n = 1'b0; up = 1'b1;
        repeat (3) tick("R3 hold en_p high");
        ep_n = 1'b0; et_n = 1'b1;
        repeat (3) tick("R3 hold en_t high");
        et_n = 1'b1;
    endtask

    task automatic t_up_seq;
        load_both(8'hF0, 8'h90, "R2 preset up");
        ep_n = 1'b0; et_n = 1'b0; up = 1'b1;
        for (int i = 0; i < 40; i++) tick("R4 R5 R9 up cascade");
        ep_n = 1'b1; et_n = 1'b1;
    endtask

    task automatic t_down_seq;
        load_both(8'h0A, 8'h08, "R2 preset down");
        ep_n = 1'b0; et_n = 1'b0; up = 1'b0;
        for (int i = 0; i < 300; i++) tick("R4 R5 R9 down cascade");
        ep_n = 1'b1; et_n = 1'b1; up = 1'b1;
    endtask

    task automatic t_long_up;
        load_both(8'h00, 8'h00, "R2 preset long");
        ep_n = 1'b0; et_n = 1'b0; up = 1'b1;
        for (int i = 0; i < 270; i++) tick("R4 R5 R9 long up");
        ep_n = 1'b1; et_n = 1'b1;
    endtask

    task automatic t_carry;
        load_both(8'h0F, 8'h09, "R6 preset");
        ep_n = 1'b0; et_n = 1'b0; up = 1'b1; #1;
        chk(bc_lo == 1'b0, "R6 bin up carry at 15", bc_lo, 0);
        chk(bc_hi == 1'b1, "R6 bin hi no carry", bc_hi, 1);
        chk(dc_lo == 1'b0, "R6 dec up carry at 9", dc_lo, 0);
        et_n = 1'b1; #1;
        chk(bc_lo == 1'b1, "R6 en_t high blocks carry", bc_lo, 1);
        ep_n = 1'b1; et_n = 1'b0; #1;
        chk(bc_lo == 1'b0, "R7 en_p high keeps carry", bc_lo, 0);
        chk(dc_lo == 1'b0, "R7 en_p high keeps dec carry", dc_lo, 0);
        up = 1'b0; #1;
        chk(bc_lo == 1'b1, "R6 down not terminal at 15", bc_lo, 1);
        load_both(8'h00, 8'h00, "R6 preset zero");
        up = 1'b0; ep_n = 1'b1; et_n = 1'b0; #1;
        chk(bc_lo == 1'b0 && bc_hi == 1'b0, "R6 down carry at 0", {bc_hi, bc_lo}, 0);
        chk(dc_lo == 1'b0 && dc_hi == 1'b0, "R6 dec down carry at 0", {dc_hi, dc_lo}, 0);
        load_both(8'hFF, 8'h99, "R6 preset full");
        up = 1'b1; #1;
        chk(bc_hi == 1'b0 && dc_hi == 1'b0, "R9 ripple carry same cycle", {bc_hi, dc_hi}, 0);
        ep_n = 1'b1; et_n = 1'b1; up = 1'b1;
    endtask

    task automatic t_oor;
        ld_n = 1'b0; dat_d = 8'h0D; dat_b = 8'h00;
        @(posedge clk); #1; ld_n = 1'b1;
        ep_n = 1'b0; et_n = 1'b0; up = 1'b1; #1;
        chk(d_lo == 4'd13, "R8 load 13", d_lo, 13);
        chk(dc_lo == 1'b1, "R8 no carry at 13", dc_lo, 1);
        @(posedge clk); #1;
        chk(d_lo == 4'd14 && d_hi == 4'd0, "R8 up 13->14", d_lo, 14);
        @(posedge clk); #1;
        chk(d_lo == 4'd15 && dc_lo == 1'b1, "R8 up 14->15 no carry", d_lo, 15);
        @(posedge clk); #1;
        chk(d_lo == 4'd0 && d_hi == 4'd0, "R8 up 15->0 no hi step", d_lo, 0);
        ld_n = 1'b0; dat_d = 8'h0C;
        @(posedge clk); #1; ld_n = 1'b1; up = 1'b0; #1;
        chk(dc_lo == 1'b1, "R8 no down carry at 12", dc_lo, 1);
        @(posedge clk); #1;
        chk(d_lo == 4'd11, "R8 down 12->11", d_lo, 11);
        ep_n = 1'b1; et_n = 1'b1; up = 1'b1;
        load_both(8'h00, 8'h00, "R2 reload after oor");
    endtask

    task automatic t_between_edges;
        load_both(8'h21, 8'h21, "R1 preset");
        ld_n = 1'b0; dat_b = 8'hEE; dat_d = 8'h77; ep_n = 1'b0; et_n = 1'b0; up = 1'b0;
        #8;
        chk({b_hi, b_lo} == 8'h21, "R1 no change before edge", int'({b_hi, b_lo}), 33);
        chk({d_hi, d_lo} == 8'h21, "R1 dec no change before edge", int'({d_hi, d_lo}), 33);
        tick("R1 change at edge");
        ld_n = 1'b1; ep_n = 1'b1; et_n = 1'b1; up = 1'b1;
    endtask

    initial begin
        #5;
        t_load();
        t_hold();
        t_up_seq();
        t_long_up();
        t_down_seq();
        t_carry();
        t_oor();
        t_between_edges();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule